// File: doc/BRIEF.md
# Debounced Edge-Select Port Interrupt

This block raises interrupts from an eight-pin input port. Each pin goes through a two-stage synchronizer and then a debounce filter. The filtered level changes only after the synchronized input has differed from it for a programmed number of consecutive clocks. A per-pin polarity bit picks whether a rising or a falling transition of the filtered level latches that pin's pending flag. The pending flags are masked by per-pin enables and combined into one registered request line for an external interrupt controller.

Software uses a small register port with a write strobe, a 2-bit address and combinational read data. One register holds the polarity bits and one holds the enables. A third holds the pending flags, which are cleared by writing 1. The fourth holds two 3-bit filter settings: one for pins 0 to 3 and one for pins 4 to 7. The filter of a pin with setting n needs 2^n equal samples before its output changes, so setting 0 gives a one-sample pass-through.

Top module: `port_edge_irq`

## Requirements
- R1: After reset, every register reads 0 and irq_o is 0. Synchronizers and filter outputs start at the idle level 1, so releasing reset with pins high sets no flag.
- R2: Registers sit at these addresses: 0 polarity (bit i = 1 selects rising for pin i, 0 selects falling), 1 enable, 2 pending flags, 3 filter settings (bits 2:0 for pins 0–3, bits 6:4 for pins 4–7). Addresses 0, 1 and 3 are written directly and read back as written.
- R3: A filtered transition matching a pin's polarity bit sets its flag. A transition of the other direction leaves the flag unchanged.
- R4: A flag sets whether or not its enable is 1.
- R5: Writing 1 to a bit of the flag register clears that flag. Writing 0 leaves it as it was.
- R6: If a selected edge and a clearing write of the same bit occur in the same cycle, the flag ends up set.
- R7: irq_o is 1 one clock after any flag with its enable set is 1, and 0 one clock after none is.
- R8: With setting n, a pin change held for 2^n clocks sets the flag exactly 2^n + 3 rising clock edges after the change is driven. A pulse shorter than 2^n clocks sets no flag.
- R9: Each filter setting acts only on its own group of four pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 8 | Port pin levels |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed register |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The vector table drives whole-port transitions. Rising and falling moves on all pins tell the two polarities apart. Mixed patterns such as 0xAA to 0x55 show that only matching-direction edges set flags. Split patterns against split enables show that flags are latched independently of the enable mask, while the request follows only enabled flags. Directed tests then measure the exact filter latency, reject a glitch shorter than the window, drive the same pulse through groups with different settings, and land a clearing write on the same cycle as a new edge.

// File: rtl/port_irq_pkg.sv
package port_irq_pkg;
  localparam int NPIN  = 8;
  localparam int GRP   = 4;
  localparam int NGRP  = NPIN / GRP;
  localparam int CFG_W = 3;
  localparam int CNT_W = (1 << CFG_W) - 1;
  localparam int AW    = 2;

  typedef enum logic [AW-1:0] {
    A_POL  = 2'd0,
    A_EN   = 2'd1,
    A_FLAG = 2'd2,
    A_CFG  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int  STAGES = 2,
  parameter logic IDLE  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= {STAGES{IDLE}};
    else        sh_q <= sh_d;
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/pin_debounce.sv
module pin_debounce
  import port_irq_pkg::*;
#(
  parameter logic IDLE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             d_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             q_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             lvl_q, lvl_d;
  logic [CNT_W:0]   lim;
  logic             cnt_en;

  // number of equal samples needed, minus one
  assign lim    = ({{CNT_W{1'b0}}, 1'b1} << cfg_i) - 1'b1;
  assign cnt_en = 1'b1;

  always_comb begin
    cnt_d = cnt_q;
    lvl_d = lvl_q;
    if (d_i == lvl_q) begin
      cnt_d = '0;
    end else if (cnt_q == lim[CNT_W-1:0]) begin
      lvl_d = d_i;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= IDLE;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign q_o = lvl_q;
endmodule

// File: rtl/port_irq_regs.sv
module port_irq_regs
  import port_irq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [AW-1:0]         addr,
  input  logic [NPIN-1:0]       wdata,
  input  logic [NPIN-1:0]       set_i,
  output logic [NPIN-1:0]       rdata,
  output logic [NPIN-1:0]       pol_o,
  output logic [NPIN-1:0]       en_o,
  output logic [NPIN-1:0]       flag_o,
  output logic [NGRP*CFG_W-1:0] cfg_o
);
  logic [NPIN-1:0]       pol_q, en_q, flag_q, flag_d, clr;
  logic [NGRP*CFG_W-1:0] cfg_q, cfg_d;
  logic                  wr_pol, wr_en_r, wr_cfg;
  logic [NPIN-1:0]       cfg_rd;

  assign wr_pol  = wr_en && (addr == A_POL);
  assign wr_en_r = wr_en && (addr == A_EN);
  assign wr_cfg  = wr_en && (addr == A_CFG);
  assign clr     = (wr_en && (addr == A_FLAG)) ? wdata : '0;

  always_comb begin
    // set has priority over clear
    flag_d = (flag_q & ~clr) | set_i;
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_cfg
    assign cfg_d[g*CFG_W +: CFG_W]  = wdata[g*GRP +: CFG_W];
    assign cfg_rd[g*GRP +: GRP]     = {{(GRP-CFG_W){1'b0}}, cfg_q[g*CFG_W +: CFG_W]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q  <= '0;
      en_q   <= '0;
      cfg_q  <= '0;
      flag_q <= '0;
    end else begin
      if (wr_pol)  pol_q <= wdata;
      if (wr_en_r) en_q  <= wdata;
      if (wr_cfg)  cfg_q <= cfg_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    unique case (addr)
      A_POL:   rdata = pol_q;
      A_EN:    rdata = en_q;
      A_FLAG:  rdata = flag_q;
      default: rdata = cfg_rd;
    endcase
  end

  assign pol_o  = pol_q;
  assign en_o   = en_q;
  assign flag_o = flag_q;
  assign cfg_o  = cfg_q;
endmodule

// File: rtl/port_edge_irq.sv
module port_edge_irq
  import port_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_i,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [NPIN-1:0] wdata,
  output logic [NPIN-1:0] rdata,
  output logic            irq_o
);
  logic [NPIN-1:0]       sync_q, filt_q, filt_d1, edge_set;
  logic [NPIN-1:0]       pol, en, flag;
  logic [NGRP*CFG_W-1:0] cfg;
  logic                  irq_q, irq_d;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    pin_sync #(.STAGES(2), .IDLE(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(pin_i[i]), .q_o(sync_q[i])
    );
    pin_debounce #(.IDLE(1'b1)) u_flt (
      .clk(clk), .rst_n(rst_n), .d_i(sync_q[i]),
      .cfg_i(cfg[(i/GRP)*CFG_W +: CFG_W]), .q_o(filt_q[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) filt_d1 <= '1;
    else        filt_d1 <= filt_q;
  end

  // a change whose new level equals the polarity bit is the selected edge
  assign edge_set = (filt_q ^ filt_d1) & ~(filt_q ^ pol);

  port_irq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .set_i(edge_set), .rdata(rdata), .pol_o(pol), .en_o(en),
    .flag_o(flag), .cfg_o(cfg)
  );

  assign irq_d = |(flag & en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/port_irq_chk.sv
module port_irq_chk
  import port_irq_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [AW-1:0]   addr,
  input logic [NPIN-1:0] wdata,
  input logic [NPIN-1:0] flag,
  input logic [NPIN-1:0] en,
  input logic [NPIN-1:0] sync_q,
  input logic [NPIN-1:0] filt_q,
  input logic [NPIN-1:0] filt_d1,
  input logic [NPIN-1:0] pol,
  input logic            irq_o
);
  logic [NPIN-1:0] keep;
  assign keep = flag & ~((wr_en && addr == A_FLAG) ? wdata : '0);

  // R7
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flag & en)) |=> irq_o);
  // R7
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(flag & en)) |=> !irq_o);
  // R5
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag & $past(keep)) == $past(keep)));
  // R3
  flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag & ~$past(flag) & ~$past((filt_q ^ filt_d1) & ~(filt_q ^ pol))) == '0));
  // R8
  filt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((filt_q ^ $past(filt_q)) & (filt_q ^ $past(sync_q))) == '0));
  // R2
  en_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_EN) |=> $stable(en));
endmodule

bind port_edge_irq port_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .flag(flag), .en(en), .sync_q(sync_q), .filt_q(filt_q),
  .filt_d1(filt_d1), .pol(pol), .irq_o(irq_o)
);

// File: tb/sim_port_edge_irq.sv
module sim_port_edge_irq;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] pin_i;
  logic       wr_en;
  logic [1:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       irq_o;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  port_edge_irq u0 (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  // cfg(8) pol en pin_a pin_b exp_flag exp_irq(8)
  localparam int NV = 6;
  localparam logic [55:0] VEC [NV] = '{
    {8'h00, 8'hFF, 8'hFF, 8'h00, 8'hFF, 8'hFF, 8'h01},
    {8'h00, 8'h00, 8'h01, 8'hFF, 8'h00, 8'hFF, 8'h01},
    {8'h00, 8'h0F, 8'h00, 8'h00, 8'h0F, 8'h0F, 8'h00},
    {8'h00, 8'hAA, 8'hFF, 8'hAA, 8'h55, 8'h00, 8'h00},
    {8'h37, 8'hF0, 8'h80, 8'h00, 8'hF0, 8'hF0, 8'h01},
    {8'h55, 8'h00, 8'h0F, 8'h3C, 8'h00, 8'h3C, 8'h01}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; pin_i = 8'hFF; wr_en = 1'b0; addr = 2'd0; wdata = 8'h00;
    waitc(3);
    @(negedge clk) rst_n = 1'b1;
    waitc(5);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v); check("R1 reset reg", v, 8'h00);
    end
    check("R1 irq", {7'd0, irq_o}, 8'h00);
    // R2 readback
    wr(2'd0, 8'h5A); rd(2'd0, v); check("R2 pol", v, 8'h5A);
    wr(2'd1, 8'hC3); rd(2'd1, v); check("R2 en", v, 8'hC3);
    wr(2'd3, 8'h75); rd(2'd3, v); check("R2 cfg", v, 8'h75);

    // table: R3 R4 R7 R9
    for (int k = 0; k < NV; k++) begin
      wr(2'd3, VEC[k][55:48]); wr(2'd0, VEC[k][47:40]); wr(2'd1, VEC[k][39:32]);
      @(negedge clk) pin_i = VEC[k][31:24];
      waitc(300);
      wr(2'd2, 8'hFF);
      @(negedge clk) pin_i = VEC[k][23:16];
      waitc(300);
      rd(2'd2, v); check($sformatf("R3 R4 vec%0d flags", k), v, VEC[k][15:8]);
      waitc(2);
      @(negedge clk) check($sformatf("R7 vec%0d irq", k), {7'd0, irq_o}, VEC[k][7:0]);
    end

    // R5 write-0 keeps, write-1 clears
    wr(2'd2, 8'h00); rd(2'd2, v); check("R5 write0", v, 8'h3C);
    wr(2'd2, 8'h0C); rd(2'd2, v); check("R5 write1", v, 8'h30);
    wr(2'd2, 8'hFF);
    waitc(2);
    @(negedge clk) check("R7 irq drop", {7'd0, irq_o}, 8'h00);

    // R8 exact latency, setting 2 (4 samples), rising pin 0
    wr(2'd3, 8'h02); wr(2'd0, 8'hFF); wr(2'd1, 8'h00);
    @(negedge clk) pin_i = 8'hFE; waitc(20); wr(2'd2, 8'hFF);
    @(negedge clk) pin_i = 8'hFF;
    waitc(6); rd(2'd2, v); check("R8 before 2^n+3", v, 8'h00);
    waitc(0);
    @(posedge clk); #1 check("R8 at 2^n+3", u0.rdata, 8'h01);
    // R8 glitch of 3 clocks rejected
    wr(2'd2, 8'hFF);
    @(negedge clk) pin_i = 8'hFE; waitc(20); wr(2'd2, 8'hFF);
    @(negedge clk) pin_i = 8'hFF; waitc(3);
    @(negedge clk) pin_i = 8'hFE; waitc(30);
    rd(2'd2, v); check("R8 glitch", v, 8'h00);

    // R9 pulse of 5 clocks: low group setting 7, high group 0
    @(negedge clk) pin_i = 8'h00; wr(2'd3, 8'h07); waitc(300); wr(2'd2, 8'hFF);
    @(negedge clk) pin_i = 8'h11; waitc(5);
    @(negedge clk) pin_i = 8'h00; waitc(300);
    rd(2'd2, v); check("R9 groups", v, 8'h10);

    // R6 set wins over same-cycle clear, setting 0, rising pin 0
    wr(2'd3, 8'h00); wr(2'd2, 8'hFF);
    @(negedge clk) pin_i = 8'h01; waitc(10);
    rd(2'd2, v); check("R6 pre", v, 8'h01);
    @(negedge clk) pin_i = 8'h00; waitc(10);
    @(negedge clk) pin_i = 8'h01;
    waitc(3);
    @(negedge clk) begin wr_en = 1'b1; addr = 2'd2; wdata = 8'h01; end
    @(negedge clk) wr_en = 1'b0;
    rd(2'd2, v); check("R6 set wins", v, 8'h01);
    wr(2'd2, 8'h01); rd(2'd2, v); check("R6 plain clear", v, 8'h00);
    done = 1;
  end

  initial begin
    waitc(20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
    end
  end

  initial begin
    wait (done == 1 || total < 0);
    #1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    if (!done && $time > 20000 * 20 + 100) begin
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule